// File: doc/BRIEF.md
# Clock Synchroniser Operating-Mode Controller

This block decides which operating mode a telecom clock synchroniser is in and tells its digitally controlled oscillator what to do: follow the selected reference, hold the frequency it had, or run from the local oscillator. It takes an active-low reset, a two-bit mode request, a reference-select level, an OK/FAIL status for the selected reference, a flag that selects manual or automatic return from automatic holdover, and a manual-return strobe.

After reset is released, an initialisation interval counted in system-clock ticks runs, and the controller then enters Free-run. From there the mode request moves it between Normal, Holdover and Free-run. A guard stops it from entering Normal while the reference is failing. If the reference fails while in Normal, the controller drops into an automatic holdover state on its own. It leaves that state either as soon as the reference recovers or, if manual return is selected, only on a rising edge of the return strobe.

A history flag records whether enough time has been spent in Normal for a stored frequency to be worth using. While the flag is clear, the holdover states fall back to free-running the oscillator.

Top module: `sync_mode_ctrl`

## Requirements
- R1: While `rstN` is 0, `stateCode` is 0 (Reset) and `holdoverFlag`, `dcoTrack`, `dcoFreeze` and `dcoFreeRun` are all 0.
- R2: After `rstN` rises, the controller stays in Reset, whatever the mode request is, for exactly INIT_TICKS rising clock edges. On the INIT_TICKS-th edge it enters Free-run (`stateCode` = 1).
- R3: Outside Reset, a synchronised mode request of 2'b10 moves the controller to Free-run on the next edge from any state. A request of 2'b11 is reserved and leaves the state unchanged.
- R4: A mode request of 2'b01 leads to Holdover (`stateCode` = 3) from Free-run, Normal or automatic holdover. From Free-run, a request of 2'b00 with an OK reference leads to Holdover for one edge. From Holdover, a request of 2'b00 with an OK reference moves to Normal (`stateCode` = 2) on the next edge.
- R5: From Free-run, a request of 2'b00 while the reference reads FAIL leads to automatic holdover (`stateCode` = 4), never to Normal.
- R6: In Normal with request 2'b00, a FAIL reading moves the controller to automatic holdover on the next edge. This takes precedence over a reference-select change seen in the same cycle.
- R7: In Normal with an OK reference and request 2'b00, any change of the reference-select level moves the controller to Holdover. It then returns to Normal on the following edge if the reference is OK.
- R8: In automatic holdover with `holdManual` = 0 and request 2'b00, an OK reading returns the controller to Normal on the next edge.
- R9: In automatic holdover with `holdManual` = 1, return to Normal needs a 0-to-1 edge on `manualRet` while the reference reads OK. An edge while the reading is FAIL has no effect, and an OK reading without an edge has no effect.
- R10: A reference-select change in automatic holdover onto an input that reads FAIL leaves the controller in automatic holdover until that input reads OK.
- R11: `holdoverFlag` is 1 exactly in Holdover and automatic holdover.
- R12: `dcoTrack` is 1 only in Normal. `dcoFreeRun` is 1 in Free-run. In the two holdover states, `dcoFreeze` is 1 if the history flag is set and `dcoFreeRun` is 1 otherwise. The history flag is set once HIST_TICKS edges have been spent in Normal in total, stays set, and is cleared only by reset.
- R13: Every input except `rstN` passes through SYNC_STAGES flip-flops. A change driven between two edges therefore first affects the state on the (SYNC_STAGES+1)-th following edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset; Reset state while 0 |
| modeSel | input | 2 | Mode request: 00 Normal, 01 Holdover, 10 Free-run, 11 reserved |
| refSel | input | 1 | Reference-select level; any change counts as a switch |
| refOk | input | 1 | 1 = selected reference OK, 0 = FAIL |
| holdManual | input | 1 | 1 = leave automatic holdover only on the manual strobe |
| manualRet | input | 1 | Manual-return strobe, acts on its rising edge |
| stateCode | output | 3 | 0 Reset, 1 Free-run, 2 Normal, 3 Holdover, 4 automatic holdover |
| holdoverFlag | output | 1 | 1 in either holdover state |
| dcoTrack | output | 1 | Oscillator follows the reference |
| dcoFreeze | output | 1 | Oscillator holds its stored frequency |
| dcoFreeRun | output | 1 | Oscillator runs from the local crystal |

## Verification
The two events that can fall in the same cycle are a reference failure and a reference-select change while in Normal. One leads toward Holdover and the other toward automatic holdover. The bench changes `refSel` and drops `refOk` at the same clock edge, so both reach the synchronised view together. It then expects automatic holdover, not Holdover, three edges later. Right after that, it switches the select again onto the still-failing input and expects the controller to stay in automatic holdover until `refOk` returns.

// File: rtl/mode_ctl_pkg.sv
`timescale 1ns/1ps
package mode_ctl_pkg;

  typedef enum logic [2:0] {
    ST_RESET    = 3'd0,
    ST_FREERUN  = 3'd1,
    ST_NORMAL   = 3'd2,
    ST_HOLD     = 3'd3,
    ST_AUTOHOLD = 3'd4
  } modeState_e;

  localparam logic [1:0] REQ_NORMAL = 2'b00;
  localparam logic [1:0] REQ_HOLD   = 2'b01;
  localparam logic [1:0] REQ_FREE   = 2'b10;
  localparam logic [1:0] REQ_RSVD   = 2'b11;

  // datapath -> control: synchronised inputs and derived strobes
  typedef struct packed {
    logic [1:0] modeSel;
    logic       refOk;
    logic       holdManual;
    logic       selChange;
    logic       manualRise;
    logic       initDone;
    logic       histValid;
  } syncView_t;

  // control -> datapath: which counter runs this cycle
  typedef struct packed {
    logic initRun;
    logic normalRun;
  } ctlStrobe_t;

endpackage

// File: rtl/mode_ctl_datapath.sv
`timescale 1ns/1ps
module mode_ctl_datapath
  import mode_ctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int INIT_TICKS  = 125000,
  parameter int HIST_TICKS  = 1000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] modeSel,
  input  logic       refSel,
  input  logic       refOk,
  input  logic       holdManual,
  input  logic       manualRet,
  input  ctlStrobe_t strobe,
  output syncView_t  view
);

  localparam int RAW_W  = 6;
  localparam int INIT_W = $clog2(INIT_TICKS + 1);
  localparam int HIST_W = $clog2(HIST_TICKS + 1);
  localparam logic [INIT_W-1:0] INIT_LAST = INIT_W'(INIT_TICKS - 1);
  localparam logic [HIST_W-1:0] HIST_FULL = HIST_W'(HIST_TICKS);

  logic [RAW_W-1:0] rawIn;
  logic [RAW_W-1:0] syncOut;
  logic [SYNC_STAGES-1:0][RAW_W-1:0] stage;

  assign rawIn = {modeSel, refSel, refOk, holdManual, manualRet};

  generate
    if (SYNC_STAGES == 1) begin : g_sync_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage <= '0;
        else       stage[0] <= rawIn;
      end
    end else begin : g_sync_chain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage <= '0;
        else       stage <= {stage[SYNC_STAGES-2:0], rawIn};
      end
    end
  endgenerate

  assign syncOut = stage[SYNC_STAGES-1];

  logic selS, mrS;
  logic selD, mrD;
  assign selS = syncOut[3];
  assign mrS  = syncOut[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selD <= 1'b0;
      mrD  <= 1'b0;
    end else begin
      selD <= selS;
      mrD  <= mrS;
    end
  end

  logic [INIT_W-1:0] initCnt;
  logic [HIST_W-1:0] histCnt;
  logic initDone, histValid;

  assign initDone  = (initCnt == INIT_LAST);
  assign histValid = (histCnt == HIST_FULL);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      initCnt <= '0;
      histCnt <= '0;
    end else begin
      if (strobe.initRun && !initDone)     initCnt <= initCnt + 1'b1;
      if (strobe.normalRun && !histValid)  histCnt <= histCnt + 1'b1;
    end
  end

  always_comb begin
    view.modeSel    = syncOut[5:4];
    view.refOk      = syncOut[2];
    view.holdManual = syncOut[1];
    view.selChange  = selS ^ selD;
    view.manualRise = mrS & ~mrD;
    view.initDone   = initDone;
    view.histValid  = histValid;
  end

endmodule

// File: rtl/mode_ctl_fsm.sv
`timescale 1ns/1ps
module mode_ctl_fsm
  import mode_ctl_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  syncView_t  view,
  output modeState_e state,
  output ctlStrobe_t strobe,
  output logic       holdoverFlag,
  output logic       dcoTrack,
  output logic       dcoFreeze,
  output logic       dcoFreeRun
);

  modeState_e nxt;

  always_comb begin
    nxt = state;
    if (state == ST_RESET) begin
      if (view.initDone) nxt = ST_FREERUN;
    end else if (view.modeSel == REQ_FREE) begin
      nxt = ST_FREERUN;
    end else if (view.modeSel != REQ_RSVD) begin
      unique case (state)
        ST_FREERUN: begin
          if (view.modeSel == REQ_HOLD) nxt = ST_HOLD;
          else                          nxt = view.refOk ? ST_HOLD : ST_AUTOHOLD;
        end
        ST_NORMAL: begin
          if (view.modeSel == REQ_HOLD) nxt = ST_HOLD;
          else if (!view.refOk)         nxt = ST_AUTOHOLD;
          else if (view.selChange)      nxt = ST_HOLD;
        end
        ST_HOLD: begin
          if (view.modeSel == REQ_NORMAL && view.refOk) nxt = ST_NORMAL;
        end
        ST_AUTOHOLD: begin
          if (view.modeSel == REQ_HOLD)
            nxt = ST_HOLD;
          else if (view.refOk && (!view.holdManual || view.manualRise))
            nxt = ST_NORMAL;
        end
        default: nxt = ST_RESET;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_RESET;
    else       state <= nxt;
  end

  logic inHold;
  assign inHold = (state == ST_HOLD) || (state == ST_AUTOHOLD);

  assign strobe.initRun   = (state == ST_RESET);
  assign strobe.normalRun = (state == ST_NORMAL);

  assign holdoverFlag = inHold;
  assign dcoTrack     = (state == ST_NORMAL);
  assign dcoFreeze    = inHold && view.histValid;
  assign dcoFreeRun   = (state == ST_FREERUN) || (inHold && !view.histValid);

endmodule

// File: rtl/sync_mode_ctrl.sv
`timescale 1ns/1ps
module sync_mode_ctrl
  import mode_ctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int INIT_TICKS  = 125000,
  parameter int HIST_TICKS  = 1000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] modeSel,
  input  logic       refSel,
  input  logic       refOk,
  input  logic       holdManual,
  input  logic       manualRet,
  output logic [2:0] stateCode,
  output logic       holdoverFlag,
  output logic       dcoTrack,
  output logic       dcoFreeze,
  output logic       dcoFreeRun
);

  syncView_t  view;
  ctlStrobe_t strobe;
  modeState_e state;

  mode_ctl_datapath #(
    .SYNC_STAGES(SYNC_STAGES),
    .INIT_TICKS (INIT_TICKS),
    .HIST_TICKS (HIST_TICKS)
  ) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .modeSel   (modeSel),
    .refSel    (refSel),
    .refOk     (refOk),
    .holdManual(holdManual),
    .manualRet (manualRet),
    .strobe    (strobe),
    .view      (view)
  );

  mode_ctl_fsm i_fsm (
    .clk         (clk),
    .rstN        (rstN),
    .view        (view),
    .state       (state),
    .strobe      (strobe),
    .holdoverFlag(holdoverFlag),
    .dcoTrack    (dcoTrack),
    .dcoFreeze   (dcoFreeze),
    .dcoFreeRun  (dcoFreeRun)
  );

  assign stateCode = state;

endmodule

// File: rtl/sync_mode_ctrl_chk.sv
`timescale 1ns/1ps
module sync_mode_ctrl_chk
  import mode_ctl_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic [2:0] stateCode,
  input syncView_t  view,
  input logic       holdoverFlag,
  input logic       dcoTrack,
  input logic       dcoFreeze,
  input logic       dcoFreeRun
);

  // R1: one edge into reset, everything is idle
  p_reset_idle_r1: assert property (@(posedge clk)
    !rstN |=> (stateCode == ST_RESET && !holdoverFlag && !dcoTrack && !dcoFreeze && !dcoFreeRun));

  p_init_exit_r2: assert property (@(posedge clk) disable iff (!rstN)
    stateCode == ST_RESET |=> (stateCode == ST_RESET || stateCode == ST_FREERUN));

  p_force_free_r3: assert property (@(posedge clk) disable iff (!rstN)
    (view.modeSel == REQ_FREE && stateCode != ST_RESET) |=> stateCode == ST_FREERUN);

  p_reserved_keep_r3: assert property (@(posedge clk) disable iff (!rstN)
    (view.modeSel == REQ_RSVD && stateCode != ST_RESET) |=> $stable(stateCode));

  p_no_normal_on_fail_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode != ST_NORMAL && !view.refOk) |=> stateCode != ST_NORMAL);

  p_fail_to_auto_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode == ST_NORMAL && view.modeSel == REQ_NORMAL && !view.refOk) |=> stateCode == ST_AUTOHOLD);

  p_manual_wait_r9: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode == ST_AUTOHOLD && view.modeSel == REQ_NORMAL && view.holdManual && !view.manualRise)
      |=> stateCode == ST_AUTOHOLD);

  p_freeze_in_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    dcoFreeze |-> holdoverFlag);

  p_dco_onehot_r12: assert property (@(posedge clk) disable iff (!rstN)
    stateCode != ST_RESET |-> $onehot({dcoTrack, dcoFreeze, dcoFreeRun}));

  p_hist_sticky_r12: assert property (@(posedge clk) disable iff (!rstN)
    view.histValid |=> view.histValid);

endmodule

bind sync_mode_ctrl sync_mode_ctrl_chk i_chk (
  .clk         (clk),
  .rstN        (rstN),
  .stateCode   (stateCode),
  .view        (view),
  .holdoverFlag(holdoverFlag),
  .dcoTrack    (dcoTrack),
  .dcoFreeze   (dcoFreeze),
  .dcoFreeRun  (dcoFreeRun)
);

// File: tb/test_sync_mode_ctrl.sv
`timescale 1ns/1ps
module test_sync_mode_ctrl;

  localparam int SYNC = 2;
  localparam int INIT = 20;
  localparam int HIST = 30;
  localparam int LAT  = SYNC + 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] modeSel = 2'b00;
  logic refSel = 1'b0;
  logic refOk = 1'b1;
  logic holdManual = 1'b0;
  logic manualRet = 1'b0;
  logic [2:0] stateCode;
  logic holdoverFlag, dcoTrack, dcoFreeze, dcoFreeRun;

  int checks = 0;
  int errors = 0;
  bit compareOn = 1'b0;
  bit done = 1'b0;
  string curReq = "R1";

  always #2.5 clk = ~clk;

  sync_mode_ctrl #(.SYNC_STAGES(SYNC), .INIT_TICKS(INIT), .HIST_TICKS(HIST)) i_sync_mode_ctrl (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .refSel(refSel), .refOk(refOk),
    .holdManual(holdManual), .manualRet(manualRet), .stateCode(stateCode),
    .holdoverFlag(holdoverFlag), .dcoTrack(dcoTrack), .dcoFreeze(dcoFreeze), .dcoFreeRun(dcoFreeRun)
  );

  // ---------------- reference model ----------------
  int mState = 0;
  int mInit = 0;
  int mHist = 0;
  bit mSelD = 0, mMrD = 0;
  logic [5:0] mPipe [$];

  initial for (int i = 0; i < SYNC; i++) mPipe.push_back(6'd0);

  function automatic int modelNext(int st, logic [1:0] ms, bit ok, bit hm, bit selChg, bit mrRise, bit initDone);
    if (st == 0) return initDone ? 1 : 0;
    if (ms == 2'b10) return 1;
    if (ms == 2'b11) return st;
    if (ms == 2'b01) return 3;
    // request Normal
    if (st == 1) return ok ? 3 : 4;
    if (st == 2) begin
      if (!ok) return 4;
      if (selChg) return 3;
      return 2;
    end
    if (st == 3) return ok ? 2 : 3;
    if (ok && (!hm || mrRise)) return 2;
    return 4;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mState = 0; mInit = 0; mHist = 0; mSelD = 0; mMrD = 0;
      for (int i = 0; i < SYNC; i++) mPipe[i] = 6'd0;
    end else begin
      logic [5:0] s;
      int nxt;
      s = mPipe[SYNC-1];
      nxt = modelNext(mState, s[5:4], s[2], s[1], s[3] != mSelD, s[0] && !mMrD, mInit == INIT-1);
      if (mState == 0 && mInit < INIT-1) mInit++;
      if (mState == 2 && mHist < HIST) mHist++;
      mSelD = s[3];
      mMrD = s[0];
      void'(mPipe.pop_back());
      mPipe.push_front({modeSel, refSel, refOk, holdManual, manualRet});
      mState = nxt;
    end
  end

  function automatic logic [7:0] modelOut();
    bit hist = (mHist == HIST);
    bit inHold = (mState == 3 || mState == 4);
    logic [2:0] code = 3'(mState);
    return {code, inHold, mState == 2, inHold && hist, mState == 1 || (inHold && !hist)};
  endfunction

  always @(negedge clk) begin
    if (compareOn && !done) begin
      logic [7:0] act, exp;
      act = {stateCode, holdoverFlag, dcoTrack, dcoFreeze, dcoFreeRun};
      exp = modelOut();
      checks++;
      if (act !== exp) begin
        errors++;
        $display("FAIL %s model compare at %0t: actual %b expected %b", curReq, $time, act, exp);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic waitEdges(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drivePoint();
    @(posedge clk);
    #1;
  endtask

  task automatic expectOut(string req, logic [2:0] st, logic hf, logic tr, logic fz, logic fr);
    logic [7:0] act, exp;
    act = {stateCode, holdoverFlag, dcoTrack, dcoFreeze, dcoFreeRun};
    exp = {st, hf, tr, fz, fr};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #100us;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired: actual running expected finished");
      done = 1'b1;
      summary();
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    // R1: reset held; mode pins request Normal with a good reference
    repeat (2) @(posedge clk);
    compareOn = 1'b1;
    waitEdges(3);
    expectOut("R1", 3'd0, 0, 0, 0, 0);

    // R2: release and count the init window
    curReq = "R2";
    drivePoint();
    rstN = 1'b1;
    waitEdges(INIT - 1);
    expectOut("R2", 3'd0, 0, 0, 0, 0);
    waitEdges(1);
    expectOut("R2", 3'd1, 0, 0, 0, 1);

    // R4: Free-run -> Holdover -> Normal with OK reference, no history yet
    curReq = "R4";
    waitEdges(1);
    expectOut("R4", 3'd3, 1, 0, 0, 1);
    waitEdges(1);
    expectOut("R4", 3'd2, 0, 1, 0, 0);

    // R12: build history in Normal
    curReq = "R12";
    waitEdges(HIST + 5);
    expectOut("R12", 3'd2, 0, 1, 0, 0);

    // R6 / R13: reference fails
    curReq = "R6";
    drivePoint();
    refOk = 1'b0;
    waitEdges(LAT - 1);
    expectOut("R13", 3'd2, 0, 1, 0, 0);
    waitEdges(1);
    expectOut("R6", 3'd4, 1, 0, 1, 0);

    // R8: automatic return
    curReq = "R8";
    drivePoint();
    refOk = 1'b1;
    waitEdges(LAT);
    expectOut("R8", 3'd2, 0, 1, 0, 0);

    // R9: manual return
    curReq = "R9";
    drivePoint();
    holdManual = 1'b1;
    refOk = 1'b0;
    waitEdges(LAT + 1);
    expectOut("R9", 3'd4, 1, 0, 1, 0);
    drivePoint();
    manualRet = 1'b1;
    waitEdges(LAT + 1);
    expectOut("R9", 3'd4, 1, 0, 1, 0);
    drivePoint();
    manualRet = 1'b0;
    refOk = 1'b1;
    waitEdges(LAT + 4);
    expectOut("R9", 3'd4, 1, 0, 1, 0);
    drivePoint();
    manualRet = 1'b1;
    waitEdges(LAT);
    expectOut("R9", 3'd2, 0, 1, 0, 0);
    drivePoint();
    manualRet = 1'b0;
    holdManual = 1'b0;
    waitEdges(LAT);

    // R7: select change in Normal passes through Holdover
    curReq = "R7";
    drivePoint();
    refSel = 1'b1;
    waitEdges(LAT);
    expectOut("R7", 3'd3, 1, 0, 1, 0);
    waitEdges(1);
    expectOut("R7", 3'd2, 0, 1, 0, 0);

    // R4 / R3: manual holdover, reserved code, back to Normal
    curReq = "R4";
    drivePoint();
    modeSel = 2'b01;
    waitEdges(LAT);
    expectOut("R4", 3'd3, 1, 0, 1, 0);
    curReq = "R3";
    drivePoint();
    modeSel = 2'b11;
    waitEdges(LAT + 3);
    expectOut("R3", 3'd3, 1, 0, 1, 0);
    curReq = "R4";
    drivePoint();
    modeSel = 2'b00;
    waitEdges(LAT);
    expectOut("R4", 3'd2, 0, 1, 0, 0);

    // R6: failure and select change in the same cycle
    curReq = "R6";
    drivePoint();
    refSel = 1'b0;
    refOk = 1'b0;
    waitEdges(LAT);
    expectOut("R6", 3'd4, 1, 0, 1, 0);

    // R10: switch onto another failing input
    curReq = "R10";
    drivePoint();
    refSel = 1'b1;
    waitEdges(LAT + 2);
    expectOut("R10", 3'd4, 1, 0, 1, 0);
    curReq = "R8";
    drivePoint();
    refOk = 1'b1;
    waitEdges(LAT);
    expectOut("R8", 3'd2, 0, 1, 0, 0);

    // R3 / R13: forced free-run latency
    curReq = "R3";
    drivePoint();
    modeSel = 2'b10;
    waitEdges(LAT - 1);
    expectOut("R13", 3'd2, 0, 1, 0, 0);
    waitEdges(1);
    expectOut("R3", 3'd1, 0, 0, 0, 1);

    // R1 / R5 / R12: second reset, Normal requested on a failing reference
    curReq = "R1";
    drivePoint();
    rstN = 1'b0;
    modeSel = 2'b00;
    refOk = 1'b0;
    waitEdges(2);
    expectOut("R1", 3'd0, 0, 0, 0, 0);
    drivePoint();
    rstN = 1'b1;
    curReq = "R2";
    waitEdges(INIT);
    expectOut("R2", 3'd1, 0, 0, 0, 1);
    curReq = "R5";
    waitEdges(1);
    expectOut("R5", 3'd4, 1, 0, 0, 1);
    curReq = "R12";
    waitEdges(4);
    expectOut("R12", 3'd4, 1, 0, 0, 1);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule